// File: doc/BRIEF.md
# Multi-Port Time Stamp Transmit Queue

This block is a shared queue that gathers residual time stamp values from several per-port sources and passes them, one per frame, to a frame builder. Each stored entry holds a 4-bit stamp value together with the 2-bit number of the port it belongs to. When the frame builder pulses `frame_start`, the oldest entry is removed. On the next cycle the block presents its port number and value, or an invalid indication if the queue held nothing.

Entries arrive from three kinds of source. The first is a processor test write, which stands in for a port's own generator while that port's injection enable is set. The second is a loopback path, which places received stamp values from every port back into the queue. The third is the per-port generators. Each source owns a one-entry holding register. A fixed-priority arbiter moves one held request per cycle into an 8-entry first-in first-out store. An occupancy state machine over that store has the states EMPTY, PARTIAL and FULL. Its transitions are: fill (EMPTY to PARTIAL on an accepted push), top-up (PARTIAL to FULL when the last slot is written), drain (PARTIAL to EMPTY when the last entry leaves) and release (FULL to PARTIAL on an accepted pop). The holding registers have two states each, free and held. An entry that cannot be stored is dropped, and a sticky overflow flag is raised.

Top module: `stamp_txq`

## Requirements
- R1: Each request from generator p with value v is stored as the entry {port p, value v}. Entries leave in the order they were stored, so an entry stored with k entries ahead of it leaves on the (k+1)-th accepted pop, and never later than the DEPTH-th pop after it was stored.
- R2: A `frame_start` pulse sampled at a clock edge removes one entry. After that edge, `pop_ack` is 1 for exactly one cycle, and `pop_valid`, `pop_port` and `pop_value` show the removed entry.
- R3: A `frame_start` on an empty queue gives `pop_ack`=1 with `pop_valid`=0 one cycle later and removes nothing.
- R4: A `cpu_wr` with `inj_en[cpu_port]`=1 stores the entry {`cpu_port`, `cpu_rts`}. A `cpu_wr` to a port whose `inj_en` bit is 0 stores nothing.
- R5: While `inj_en[p]`=1, requests from generator p are discarded. Generators of other ports are unaffected.
- R6: While `lb_en`=1, every asserted `rx_valid[p]` stores {port p, received value}. While `lb_en`=0, received values are ignored.
- R7: Requests arriving in the same cycle are stored in this fixed priority order: processor injection first, then loopback ports 0 to 3, then generators 0 to 3. One request is stored per cycle.
- R8: A request served while the store holds DEPTH entries (8 by default) is dropped. Fullness is judged before that cycle's pop. The drop sets `overflow`, which stays 1 until reset.
- R9: A new request to a source whose holding register is still occupied, and not being served in that cycle, is dropped and sets `overflow`.
- R10: After reset the queue is empty, `pop_ack`, `pop_valid` and `overflow` are 0, and all holding registers are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_valid | input | NPORT | Per-port generator strobe |
| gen_value | input | NPORT*VW | Per-port generator values, port p at bits [p*VW +: VW] |
| inj_en | input | NPORT | Per-port injection enable |
| cpu_wr | input | 1 | Processor test write strobe |
| cpu_port | input | PW | Port addressed by the test write |
| cpu_rts | input | VW | Stamp field of the test write |
| lb_en | input | 1 | Received-value loopback enable |
| rx_valid | input | NPORT | Per-port received value strobe |
| rx_value | input | NPORT*VW | Per-port received values, port p at bits [p*VW +: VW] |
| frame_start | input | 1 | Pop request at the start of each frame |
| pop_ack | output | 1 | One-cycle answer to a frame_start |
| pop_valid | output | 1 | The answer carries an entry |
| pop_port | output | PW | Source port of the popped entry |
| pop_value | output | VW | Stamp value of the popped entry |
| overflow | output | 1 | Sticky flag: an entry was lost |

## Verification
The hardest case to reach from the ports is a lost request in a holding register. It occurs only when a source is still waiting because a higher-priority source took its cycle, and that same source then asks again. The stimulus forces this by issuing an injection and a generator 0 request together, then a second generator 0 request one cycle later. A separate stimulus places all nine sources in one cycle, which fills the store to exactly its depth in priority order. Further pushes then reach the full-store drop.

// File: rtl/stq_pkg.sv
package stq_pkg;

    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } occ_state_t;

    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_state_t;

endpackage

// File: rtl/stq_slot.sv
module stq_slot
    import stq_pkg::*;
#(
    parameter int unsigned EW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arr_v,
    input  logic [EW-1:0] arr_d,
    input  logic          take,
    output logic          held,
    output logic [EW-1:0] data,
    output logic          lost
);

    slot_state_t st_q, st_d;
    logic [EW-1:0] data_q;
    logic          load;

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        lost = 1'b0;
        unique case (st_q)
            SLOT_FREE: begin
                if (arr_v) begin
                    st_d = SLOT_HELD;
                    load = 1'b1;
                end
            end
            SLOT_HELD: begin
                if (take) begin
                    if (arr_v) begin
                        load = 1'b1;
                    end else begin
                        st_d = SLOT_FREE;
                    end
                end else if (arr_v) begin
                    lost = 1'b1;
                end
            end
            default: st_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SLOT_FREE;
            data_q <= '0;
        end else begin
            st_q <= st_d;
            if (load) begin
                data_q <= arr_d;
            end
        end
    end

    assign held = (st_q == SLOT_HELD);
    assign data = data_q;

    // R9
    take_needs_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> held);

endmodule

// File: rtl/stq_arb.sv
module stq_arb #(
    parameter int unsigned N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);

    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (req[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    // R7
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && ((|req) == (|gnt)));

    // R7
    grant_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req[0] |-> gnt[0]);

endmodule

// File: rtl/stq_fifo.sv
module stq_fifo
    import stq_pkg::*;
#(
    parameter int unsigned EW    = 6,
    parameter int unsigned DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [EW-1:0] wdata,
    input  logic          pop,
    output logic [EW-1:0] rdata,
    output logic          empty,
    output logic          full,
    output logic          drop
);

    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CMAX = CW'(DEPTH);

    occ_state_t occ_q, occ_d;
    logic [EW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          acc_push, acc_pop;

    assign acc_push = push && (occ_q != Q_FULL);
    assign acc_pop  = pop  && (occ_q != Q_EMPTY);
    assign drop     = push && (occ_q == Q_FULL);

    always_comb begin
        occ_d = occ_q;
        unique case (occ_q)
            Q_EMPTY: begin
                if (acc_push) begin
                    occ_d = (DEPTH == 1) ? Q_FULL : Q_PARTIAL;
                end
            end
            Q_PARTIAL: begin
                if (acc_push && !acc_pop && (count == CMAX - 1'b1)) begin
                    occ_d = Q_FULL;
                end else if (acc_pop && !acc_push && (count == CW'(1))) begin
                    occ_d = Q_EMPTY;
                end
            end
            Q_FULL: begin
                if (acc_pop) begin
                    occ_d = (DEPTH == 1) ? Q_EMPTY : Q_PARTIAL;
                end
            end
            default: occ_d = Q_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= Q_EMPTY;
        end else begin
            occ_q <= occ_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (acc_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (acc_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            if (acc_push && !acc_pop) begin
                count <= count + 1'b1;
            end else if (acc_pop && !acc_push) begin
                count <= count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (acc_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    assign rdata = mem[rd_ptr];
    assign empty = (occ_q == Q_EMPTY);
    assign full  = (occ_q == Q_FULL);

    // R8
    full_vs_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((occ_q == Q_FULL) == (count == CMAX)) && ((occ_q == Q_EMPTY) == (count == '0)));

    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> (full && $stable(wr_ptr)));

    // R3
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> (empty && $stable(rd_ptr)));

endmodule

// File: rtl/stamp_txq.sv
module stamp_txq #(
    parameter int unsigned NPORT = 4,
    parameter int unsigned VW    = 4,
    parameter int unsigned DEPTH = 8,
    parameter int unsigned PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPORT-1:0]    gen_valid,
    input  logic [NPORT*VW-1:0] gen_value,
    input  logic [NPORT-1:0]    inj_en,
    input  logic                cpu_wr,
    input  logic [PW-1:0]       cpu_port,
    input  logic [VW-1:0]       cpu_rts,
    input  logic                lb_en,
    input  logic [NPORT-1:0]    rx_valid,
    input  logic [NPORT*VW-1:0] rx_value,
    input  logic                frame_start,
    output logic                pop_ack,
    output logic                pop_valid,
    output logic [PW-1:0]       pop_port,
    output logic [VW-1:0]       pop_value,
    output logic                overflow
);

    localparam int unsigned EW    = PW + VW;
    localparam int unsigned NSRC  = 1 + 2 * NPORT;
    localparam int unsigned LB0   = 1;
    localparam int unsigned GEN0  = 1 + NPORT;

    logic [NSRC-1:0] arr_v, held, take, lost;
    logic [EW-1:0]   arr_d [NSRC];
    logic [EW-1:0]   held_d [NSRC];
    logic            push, q_empty, q_full, q_drop;
    logic [EW-1:0]   push_d, q_rdata;
    logic            ovf_q, ack_q, val_q;
    logic [EW-1:0]   out_q;

    // source 0: processor injection, tagged with the addressed port
    assign arr_v[0] = cpu_wr && inj_en[cpu_port];
    assign arr_d[0] = {cpu_port, cpu_rts};

    for (genvar p = 0; p < int'(NPORT); p++) begin : g_src
        assign arr_v[LB0 + p]  = lb_en && rx_valid[p];
        assign arr_d[LB0 + p]  = {PW'(p), rx_value[p*VW +: VW]};
        assign arr_v[GEN0 + p] = gen_valid[p] && !inj_en[p];
        assign arr_d[GEN0 + p] = {PW'(p), gen_value[p*VW +: VW]};
    end

    for (genvar s = 0; s < int'(NSRC); s++) begin : g_slot
        stq_slot #(.EW(EW)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .arr_v (arr_v[s]),
            .arr_d (arr_d[s]),
            .take  (take[s]),
            .held  (held[s]),
            .data  (held_d[s]),
            .lost  (lost[s])
        );
    end

    stq_arb #(.N(NSRC)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (held),
        .gnt   (take)
    );

    always_comb begin
        push_d = '0;
        for (int s = 0; s < int'(NSRC); s++) begin
            if (take[s]) begin
                push_d = push_d | held_d[s];
            end
        end
    end

    assign push = |take;

    stq_fifo #(.EW(EW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (push_d),
        .pop   (frame_start),
        .rdata (q_rdata),
        .empty (q_empty),
        .full  (q_full),
        .drop  (q_drop)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            ack_q <= 1'b0;
            val_q <= 1'b0;
            out_q <= '0;
        end else begin
            ovf_q <= ovf_q || q_drop || (|lost);
            ack_q <= frame_start;
            val_q <= frame_start && !q_empty;
            if (frame_start && !q_empty) begin
                out_q <= q_rdata;
            end
        end
    end

    assign pop_ack   = ack_q;
    assign pop_valid = val_q;
    assign pop_port  = out_q[EW-1 -: PW];
    assign pop_value = out_q[VW-1:0];
    assign overflow  = ovf_q;

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R3
    empty_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && q_empty) |=> (pop_ack && !pop_valid));

    // R2
    valid_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> pop_ack);

    // R8
    full_drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && q_full) |=> overflow);

    for (genvar p = 0; p < int'(NPORT); p++) begin : g_gen_chk
        // R5
        gen_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (inj_en[p] && !held[GEN0 + p]) |=> !held[GEN0 + p]);
    end

endmodule

// File: tb/stamp_txq_bench.sv
module stamp_txq_bench;

    localparam int NPORT = 4;
    localparam int VW    = 4;
    localparam int DEPTH = 8;
    localparam int PW    = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NPORT-1:0]    gen_valid = '0;
    logic [NPORT*VW-1:0] gen_value = '0;
    logic [NPORT-1:0]    inj_en = '0;
    logic                cpu_wr = 1'b0;
    logic [PW-1:0]       cpu_port = '0;
    logic [VW-1:0]       cpu_rts = '0;
    logic                lb_en = 1'b0;
    logic [NPORT-1:0]    rx_valid = '0;
    logic [NPORT*VW-1:0] rx_value = '0;
    logic                frame_start = 1'b0;
    logic                pop_ack, pop_valid, overflow;
    logic [PW-1:0]       pop_port;
    logic [VW-1:0]       pop_value;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    stamp_txq #(.NPORT(NPORT), .VW(VW), .DEPTH(DEPTH)) u_stamp_txq (
        .clk(clk), .rst_n(rst_n), .gen_valid(gen_valid), .gen_value(gen_value),
        .inj_en(inj_en), .cpu_wr(cpu_wr), .cpu_port(cpu_port), .cpu_rts(cpu_rts),
        .lb_en(lb_en), .rx_valid(rx_valid), .rx_value(rx_value),
        .frame_start(frame_start), .pop_ack(pop_ack), .pop_valid(pop_valid),
        .pop_port(pop_port), .pop_value(pop_value), .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
    endtask

    // pop one entry; expected entry packed as port*16+value
    task automatic pop_expect(input bit ev, input int ep, input int evl, input string req);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        check(pop_ack == 1'b1, {req, " ack"}, int'(pop_ack), 1);
        check(pop_valid == ev, {req, " valid"}, int'(pop_valid), int'(ev));
        if (ev) begin
            check((int'(pop_port) * 16 + int'(pop_value)) == (ep * 16 + evl),
                  {req, " entry"}, int'(pop_port) * 16 + int'(pop_value), ep * 16 + evl);
        end
        @(negedge clk);
        check(pop_ack == 1'b0, {req, " ack pulse"}, int'(pop_ack), 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        do_reset();

        // R10: reset state
        check(pop_ack == 1'b0, "R10 ack", int'(pop_ack), 0);
        check(pop_valid == 1'b0, "R10 valid", int'(pop_valid), 0);
        check(overflow == 1'b0, "R10 overflow", int'(overflow), 0);
        pop_expect(1'b0, 0, 0, "R10 empty after reset");

        // R1, R2: sweep every port and every value through the generator path
        for (int p = 0; p < NPORT; p++) begin
            for (int v = 0; v < 16; v++) begin
                gen_valid[p] = 1'b1;
                gen_value[p*VW +: VW] = VW'(v);
                wait_cyc(1);
                gen_valid = '0;
                wait_cyc(3);
                pop_expect(1'b1, p, v, "R1 R2 sweep");
            end
        end
        // R3: queue now empty
        pop_expect(1'b0, 0, 0, "R3 empty pop");

        // R1: FIFO order for a burst of stores on one port
        for (int k = 0; k < 6; k++) begin
            gen_valid[1] = 1'b1;
            gen_value[1*VW +: VW] = VW'((k * 7 + 2) % 16);
            wait_cyc(1);
        end
        gen_valid = '0;
        wait_cyc(4);
        for (int k = 0; k < 6; k++) pop_expect(1'b1, 1, (k * 7 + 2) % 16, "R1 order");
        pop_expect(1'b0, 0, 0, "R3 after burst");

        // R4: injection disabled, processor write ignored
        cpu_wr = 1'b1; cpu_port = 2'd3; cpu_rts = 4'd11;
        wait_cyc(1);
        cpu_wr = 1'b0;
        wait_cyc(4);
        pop_expect(1'b0, 0, 0, "R4 write ignored when disabled");

        // R4, R5: injection on port 3 for every value, generator 3 discarded,
        // generator 0 still served
        inj_en = 4'b1000;
        for (int v = 0; v < 16; v++) begin
            cpu_wr = 1'b1; cpu_port = 2'd3; cpu_rts = VW'(v);
            gen_valid = 4'b1001;
            gen_value = {4'(15 - v), 4'd0, 4'd0, 4'(v ^ 5)};
            wait_cyc(1);
            cpu_wr = 1'b0; gen_valid = '0;
            wait_cyc(4);
            pop_expect(1'b1, 3, v, "R4 injected entry");
            pop_expect(1'b1, 0, v ^ 5, "R5 other port kept");
            pop_expect(1'b0, 0, 0, "R5 blocked generator discarded");
        end
        inj_en = '0;

        // R6: loopback disabled, received values ignored
        rx_valid = 4'b1111; rx_value = 16'h4321;
        wait_cyc(1);
        rx_valid = '0;
        wait_cyc(4);
        pop_expect(1'b0, 0, 0, "R6 loopback off");

        // R6: loopback enabled, all ports stored in port order
        lb_en = 1'b1;
        for (int r = 0; r < 4; r++) begin
            rx_valid = 4'b1111;
            for (int p = 0; p < NPORT; p++) rx_value[p*VW +: VW] = VW'((p * 3 + r * 5) % 16);
            wait_cyc(1);
            rx_valid = '0;
            wait_cyc(6);
            for (int p = 0; p < NPORT; p++) pop_expect(1'b1, p, (p * 3 + r * 5) % 16, "R6 loopback");
            pop_expect(1'b0, 0, 0, "R6 loopback drained");
        end

        // R7: all sources at once, port 2 injected, fills exactly DEPTH entries
        inj_en = 4'b0100;
        cpu_wr = 1'b1; cpu_port = 2'd2; cpu_rts = 4'd10;
        rx_valid = 4'b1111; rx_value = 16'h8642;
        gen_valid = 4'b1111; gen_value = 16'hFEDC;
        wait_cyc(1);
        cpu_wr = 1'b0; rx_valid = '0; gen_valid = '0;
        wait_cyc(12);
        pop_expect(1'b1, 2, 10, "R7 injection first");
        for (int p = 0; p < NPORT; p++) pop_expect(1'b1, p, 2 + 2 * p, "R7 loopback next");
        pop_expect(1'b1, 0, 12, "R7 gen0");
        pop_expect(1'b1, 1, 13, "R7 gen1");
        pop_expect(1'b1, 3, 15, "R7 gen3");
        pop_expect(1'b0, 0, 0, "R7 drained");
        check(overflow == 1'b0, "R7 no loss at exact depth", int'(overflow), 0);
        inj_en = '0; lb_en = 1'b0;

        // R8: DEPTH+1 stores, last dropped, overflow sticky
        for (int k = 0; k <= DEPTH; k++) begin
            gen_valid[0] = 1'b1;
            gen_value[0 +: VW] = VW'(k);
            wait_cyc(1);
        end
        gen_valid = '0;
        wait_cyc(4);
        check(overflow == 1'b1, "R8 overflow set", int'(overflow), 1);
        for (int k = 0; k < DEPTH; k++) pop_expect(1'b1, 0, k, "R8 kept entries");
        pop_expect(1'b0, 0, 0, "R8 extra dropped");
        wait_cyc(5);
        check(overflow == 1'b1, "R8 overflow sticky", int'(overflow), 1);

        // R9: holding register collision
        do_reset();
        check(overflow == 1'b0, "R10 overflow cleared", int'(overflow), 0);
        inj_en = 4'b0010;
        cpu_wr = 1'b1; cpu_port = 2'd1; cpu_rts = 4'd9;
        gen_valid = 4'b0001; gen_value = 16'h0004;
        wait_cyc(1);
        cpu_wr = 1'b0;
        gen_value = 16'h0005;
        wait_cyc(1);
        gen_valid = '0;
        wait_cyc(4);
        check(overflow == 1'b1, "R9 collision overflow", int'(overflow), 1);
        pop_expect(1'b1, 1, 9, "R9 injection kept");
        pop_expect(1'b1, 0, 4, "R9 held entry kept");
        pop_expect(1'b0, 0, 0, "R9 second request lost");
        inj_en = '0;

        done = 1'b1;
        finish_run();
    end

endmodule